// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits next to the transmit and receive FIFOs of a serial peripheral controller and turns their state into the flags that software and a DMA engine use. It takes the FIFO fill levels, the full and empty indications, the host push and pop strobes, the engine's write strobe into the receive FIFO and the engine busy flag. From these inputs it builds a five-bit status word, a raw interrupt vector, a masked interrupt vector, one registered interrupt line and two DMA request lines.

The block holds the configuration that shapes these outputs: a transmit threshold, a receive threshold, an interrupt mask, a two-bit DMA enable and one watermark per direction. Each register has its own write strobe and all share one write data bus, because the address decode lives outside the block. Error events (transmit overflow, receive underflow, receive overflow) are sticky and are removed through a write-to-clear strobe. The clear register orders its bits differently from the interrupt vector and has one bit that clears everything. The two level sources follow the FIFO levels and cannot be cleared.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: `status` bit 0 is busy, bit 1 is TX full, bit 2 is TX empty, bit 3 is RX empty and bit 4 is RX full. Each bit follows its input in the same cycle.
- R2: Raw interrupt bit 1 (TX overflow) becomes 1 in the cycle after a cycle in which `tx_push` and `tx_full` are both high.
- R3: Raw bit 2 (RX underflow) becomes 1 in the cycle after `rx_pop` while `rx_empty` is high. Raw bit 3 (RX overflow) becomes 1 in the cycle after `rx_wr` while `rx_full` is high.
- R4: Raw bits 1 to 3 stay at 1 until a `wr_clr` cycle clears them. `wdata` bit 0 clears all three, bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. A new event in the same cycle as its clear leaves the bit set.
- R5: Raw bit 0 is 1 while `tx_level` <= TX threshold. Raw bit 4 is 1 while `rx_level` > RX threshold. A clear write has no effect on either bit.
- R6: `masked_irq` equals `raw_irq` AND the mask. The mask is written from `wdata[4:0]` by `wr_mask`, and mask bit n enables raw bit n.
- R7: `irq` is 1 exactly when `masked_irq` was non-zero in the previous cycle.
- R8: `tx_dma_req` is DMA enable bit 1 AND (`tx_level` <= TX watermark). `rx_dma_req` is DMA enable bit 0 AND (`rx_level` > RX watermark). The enables are written from `wdata[1:0]` by `wr_dma`.
- R9: After reset, both thresholds, both watermarks, the mask, the DMA enables, the sticky bits and `irq` are all 0.
- R10: A register write takes effect on the outputs in the cycle after its strobe. Thresholds and watermarks take `wdata[LVL_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Serial engine busy |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| tx_push | input | 1 | Host write into TX FIFO |
| rx_pop | input | 1 | Host read from RX FIFO |
| rx_wr | input | 1 | Engine write into RX FIFO |
| wdata | input | WDATA_W | Shared register write data |
| wr_tx_thr | input | 1 | Write TX threshold |
| wr_rx_thr | input | 1 | Write RX threshold |
| wr_mask | input | 1 | Write interrupt mask |
| wr_clr | input | 1 | Write-to-clear strobe |
| wr_dma | input | 1 | Write DMA enables |
| wr_tx_wm | input | 1 | Write TX DMA watermark |
| wr_rx_wm | input | 1 | Write RX DMA watermark |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Registered combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The hardest case to reach is a sticky event and its own clear bit arriving in the same cycle. A close second is a clear-all write that lands while a different error source is firing. Random stimulus almost never lines these up, so directed sequences drive `tx_push` with `tx_full`, `rx_pop` with `rx_empty`, and `rx_wr` with `rx_full`, together with `wr_clr` patterns that use each clear bit and the clear-all bit. Levels are then forced to equal the thresholds and watermarks so that both sides of each comparison are exercised. A long random phase with sparse register writes follows, checked every cycle against a bench model.

// File: rtl/spi_fifo_irq_pkg.sv
`timescale 1ns/1ps
package spi_fifo_irq_pkg;

    localparam int NUM_IRQ    = 5;
    localparam int NUM_STICKY = 3;
    localparam int CLR_W      = 4;
    localparam int DMA_W      = 2;

    // Status word, busy in bit 0
    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_t;

    // Interrupt vector, TX low-level source in bit 0
    typedef struct packed {
        logic rx_above;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
        logic tx_low;
    } irq_t;

    typedef enum logic {
        CMP_AT_OR_BELOW = 1'b0,
        CMP_ABOVE       = 1'b1
    } cmp_e;

    // Sticky index order: 0 tx_ovf, 1 rx_unf, 2 rx_ovf
    function automatic logic [NUM_STICKY-1:0] sticky_clear_map(input logic [CLR_W-1:0] c);
        return {c[0] | c[2], c[0] | c[1], c[0] | c[3]};
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import spi_fifo_irq_pkg::*;
#(
    parameter int LVL_W   = 6,
    parameter int WDATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WDATA_W-1:0] wdata,
    input  logic               wr_tx_thr,
    input  logic               wr_rx_thr,
    input  logic               wr_mask,
    input  logic               wr_dma,
    input  logic               wr_tx_wm,
    input  logic               wr_rx_wm,
    output logic [LVL_W-1:0]   tx_thr,
    output logic [LVL_W-1:0]   rx_thr,
    output logic [LVL_W-1:0]   tx_wm,
    output logic [LVL_W-1:0]   rx_wm,
    output logic [NUM_IRQ-1:0] mask,
    output logic [DMA_W-1:0]   dma_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr <= '0;
            rx_thr <= '0;
            tx_wm  <= '0;
            rx_wm  <= '0;
            mask   <= '0;
            dma_en <= '0;
        end else begin
            if (wr_tx_thr) tx_thr <= wdata[LVL_W-1:0];
            if (wr_rx_thr) rx_thr <= wdata[LVL_W-1:0];
            if (wr_tx_wm)  tx_wm  <= wdata[LVL_W-1:0];
            if (wr_rx_wm)  rx_wm  <= wdata[LVL_W-1:0];
            if (wr_mask)   mask   <= wdata[NUM_IRQ-1:0];
            if (wr_dma)    dma_en <= wdata[DMA_W-1:0];
        end
    end
endmodule

// File: rtl/irq_level_cmp.sv
`timescale 1ns/1ps
module irq_level_cmp
    import spi_fifo_irq_pkg::*;
#(
    parameter int   LVL_W = 6,
    parameter cmp_e MODE  = CMP_AT_OR_BELOW
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] limit,
    output logic             hit
);
    generate
        if (MODE == CMP_ABOVE) begin : g_above
            assign hit = (level > limit);
        end else begin : g_below
            assign hit = (level <= limit);
        end
    endgenerate
endmodule

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/1ps
module irq_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)            flags[i] <= 1'b0;
                else if (set_ev[i]) flags[i] <= 1'b1;
                else if (clr_ev[i]) flags[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int WDATA_W = 16,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               tx_full,
    input  logic               tx_empty,
    input  logic               rx_full,
    input  logic               rx_empty,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               tx_push,
    input  logic               rx_pop,
    input  logic               rx_wr,
    input  logic [WDATA_W-1:0] wdata,
    input  logic               wr_tx_thr,
    input  logic               wr_rx_thr,
    input  logic               wr_mask,
    input  logic               wr_clr,
    input  logic               wr_dma,
    input  logic               wr_tx_wm,
    input  logic               wr_rx_wm,
    output logic [4:0]         status,
    output logic [4:0]         raw_irq,
    output logic [4:0]         masked_irq,
    output logic               irq,
    output logic               tx_dma_req,
    output logic               rx_dma_req
);
    logic [LVL_W-1:0]      tx_thr, rx_thr, tx_wm, rx_wm;
    logic [NUM_IRQ-1:0]    mask;
    logic [DMA_W-1:0]      dma_en;
    logic [NUM_STICKY-1:0] sticky_set, sticky_clr, sticky_q;
    logic                  tx_low, rx_above, tx_wm_hit, rx_wm_hit;
    stat_t                 st;
    irq_t                  rv;

    irq_cfg_regs #(.LVL_W(LVL_W), .WDATA_W(WDATA_W)) u_cfg (
        .clk(clk), .rst(rst), .wdata(wdata),
        .wr_tx_thr(wr_tx_thr), .wr_rx_thr(wr_rx_thr), .wr_mask(wr_mask),
        .wr_dma(wr_dma), .wr_tx_wm(wr_tx_wm), .wr_rx_wm(wr_rx_wm),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .mask(mask), .dma_en(dma_en)
    );

    irq_level_cmp #(.LVL_W(LVL_W), .MODE(CMP_AT_OR_BELOW)) u_tx_thr (
        .level(tx_level), .limit(tx_thr), .hit(tx_low));
    irq_level_cmp #(.LVL_W(LVL_W), .MODE(CMP_ABOVE)) u_rx_thr (
        .level(rx_level), .limit(rx_thr), .hit(rx_above));
    irq_level_cmp #(.LVL_W(LVL_W), .MODE(CMP_AT_OR_BELOW)) u_tx_wm (
        .level(tx_level), .limit(tx_wm), .hit(tx_wm_hit));
    irq_level_cmp #(.LVL_W(LVL_W), .MODE(CMP_ABOVE)) u_rx_wm (
        .level(rx_level), .limit(rx_wm), .hit(rx_wm_hit));

    // Sticky order: 0 tx_ovf, 1 rx_unf, 2 rx_ovf
    assign sticky_set = {rx_wr & rx_full, rx_pop & rx_empty, tx_push & tx_full};
    assign sticky_clr = wr_clr ? sticky_clear_map(wdata[CLR_W-1:0]) : '0;

    irq_sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk(clk), .rst(rst), .set_ev(sticky_set), .clr_ev(sticky_clr), .flags(sticky_q));

    always_comb begin
        st.busy     = busy;
        st.tx_full  = tx_full;
        st.tx_empty = tx_empty;
        st.rx_empty = rx_empty;
        st.rx_full  = rx_full;

        rv.tx_low   = tx_low;
        rv.tx_ovf   = sticky_q[0];
        rv.rx_unf   = sticky_q[1];
        rv.rx_ovf   = sticky_q[2];
        rv.rx_above = rx_above;
    end

    assign status     = st;
    assign raw_irq    = rv;
    assign masked_irq = rv & mask;
    assign tx_dma_req = dma_en[1] & tx_wm_hit;
    assign rx_dma_req = dma_en[0] & rx_wm_hit;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |masked_irq;
    end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
`timescale 1ns/1ps
module spi_fifo_irq_chk #(
    parameter int LVL_W   = 6,
    parameter int WDATA_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_full,
    input logic               rx_full,
    input logic               rx_empty,
    input logic               tx_push,
    input logic               rx_pop,
    input logic               rx_wr,
    input logic [WDATA_W-1:0] wdata,
    input logic               wr_clr,
    input logic               wr_dma,
    input logic [4:0]         raw_irq,
    input logic [4:0]         masked_irq,
    input logic               irq,
    input logic               tx_dma_req,
    input logic               rx_dma_req
);
    AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full) |=> raw_irq[1]); // R2
    AST_RX_UNF_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |=> raw_irq[2]); // R3
    AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_wr && rx_full) |=> raw_irq[3]); // R3
    AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (raw_irq[1] && !(wr_clr && (wdata[0] || wdata[3]))) |=> raw_irq[1]); // R4
    AST_RX_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (raw_irq[2] && !(wr_clr && (wdata[0] || wdata[1]))) |=> raw_irq[2]); // R4
    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (masked_irq & ~raw_irq) == 5'd0); // R6
    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
        (|masked_irq) |=> irq); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (masked_irq == 5'd0) |=> !irq); // R7
    AST_DMA_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wdata[1:0] == 2'b00) |=> (!tx_dma_req && !rx_dma_req)); // R8
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.LVL_W(LVL_W), .WDATA_W(WDATA_W)) u_chk (
    .clk(clk), .rst(rst), .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_push(tx_push), .rx_pop(rx_pop), .rx_wr(rx_wr), .wdata(wdata), .wr_clr(wr_clr),
    .wr_dma(wr_dma), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/sim_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_unit;
    localparam int DEPTH   = 32;
    localparam int WDATA_W = 16;
    localparam int LVL_W   = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic busy = 0, tx_full = 0, tx_empty = 0, rx_full = 0, rx_empty = 0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic tx_push = 0, rx_pop = 0, rx_wr = 0;
    logic [WDATA_W-1:0] wdata = '0;
    logic wr_tx_thr = 0, wr_rx_thr = 0, wr_mask = 0, wr_clr = 0, wr_dma = 0, wr_tx_wm = 0, wr_rx_wm = 0;
    logic [4:0] status, raw_irq, masked_irq;
    logic irq, tx_dma_req, rx_dma_req;

    always #10 clk = ~clk;

    spi_fifo_irq_unit #(.DEPTH(DEPTH), .WDATA_W(WDATA_W)) u0 (
        .clk(clk), .rst(rst), .busy(busy), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_pop(rx_pop), .rx_wr(rx_wr), .wdata(wdata),
        .wr_tx_thr(wr_tx_thr), .wr_rx_thr(wr_rx_thr), .wr_mask(wr_mask), .wr_clr(wr_clr),
        .wr_dma(wr_dma), .wr_tx_wm(wr_tx_wm), .wr_rx_wm(wr_rx_wm),
        .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    // Bench model state
    logic [LVL_W-1:0] m_tx_thr = '0, m_rx_thr = '0, m_tx_wm = '0, m_rx_wm = '0;
    logic [4:0] m_mask = '0;
    logic [1:0] m_dma = '0;
    logic [2:0] m_stk = '0;   // {rx_ovf, rx_unf, tx_ovf}
    logic       m_irq = 1'b0;
    int n_vec = 0, n_err = 0;
    bit done = 0;

    function automatic logic [4:0] exp_status();
        return {rx_full, rx_empty, tx_empty, tx_full, busy};
    endfunction
    function automatic logic [4:0] exp_raw();
        return {rx_level > m_rx_thr, m_stk[2], m_stk[1], m_stk[0], tx_level <= m_tx_thr};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        tx_push = 0; rx_pop = 0; rx_wr = 0;
        wr_tx_thr = 0; wr_rx_thr = 0; wr_mask = 0; wr_clr = 0;
        wr_dma = 0; wr_tx_wm = 0; wr_rx_wm = 0;
    endtask

    // Called at a negedge with inputs set; checks, advances model, returns at next negedge
    task automatic step();
        logic [4:0] r;
        logic [2:0] clrm;
        #2;
        r = exp_raw();
        chk("R1 status", status, exp_status());
        chk("R5 threshold bits", {raw_irq[4], raw_irq[0]}, {r[4], r[0]});
        chk("R2 R3 R4 sticky bits", raw_irq[3:1], r[3:1]);
        chk("R6 masked", masked_irq, r & m_mask);
        chk("R7 irq", irq, m_irq);
        chk("R8 dma", {tx_dma_req, rx_dma_req},
            {m_dma[1] & (tx_level <= m_tx_wm), m_dma[0] & (rx_level > m_rx_wm)});
        clrm = wr_clr ? {wdata[0] | wdata[2], wdata[0] | wdata[1], wdata[0] | wdata[3]} : 3'b000;
        m_irq = |(r & m_mask);
        m_stk = (m_stk & ~clrm) | {rx_wr & rx_full, rx_pop & rx_empty, tx_push & tx_full};
        if (wr_tx_thr) m_tx_thr = wdata[LVL_W-1:0];
        if (wr_rx_thr) m_rx_thr = wdata[LVL_W-1:0];
        if (wr_tx_wm)  m_tx_wm  = wdata[LVL_W-1:0];
        if (wr_rx_wm)  m_rx_wm  = wdata[LVL_W-1:0];
        if (wr_mask)   m_mask   = wdata[4:0];
        if (wr_dma)    m_dma    = wdata[1:0];
        @(negedge clk);
        idle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state, levels 0 -> only TX low source raw
        #2;
        chk("R9 reset raw", raw_irq, 5'b00001);
        chk("R9 reset masked", masked_irq, 5'd0);
        chk("R9 reset irq/dma", {irq, tx_dma_req, rx_dma_req}, 3'b000);
        @(negedge clk);

        // Enable all mask bits
        wdata = 16'h001F; wr_mask = 1; step();
        step();

        // R2: push while TX full
        tx_full = 1; tx_push = 1; step();
        tx_full = 0; step();
        // R3: pop while RX empty, engine write while RX full
        rx_empty = 1; rx_pop = 1; step();
        rx_empty = 0; rx_full = 1; rx_wr = 1; step();
        rx_full = 0; step();
        // R4: clear bit1 clears RX underflow only
        wdata = 16'h0002; wr_clr = 1; step();
        #2; chk("R4 clear rx_unf", raw_irq[3:1], 3'b101); @(negedge clk);
        // R4: clear TX overflow while it re-fires -> stays set
        tx_full = 1; tx_push = 1; wdata = 16'h0008; wr_clr = 1; step();
        tx_full = 0;
        #2; chk("R4 set beats clear", raw_irq[1], 1'b1); @(negedge clk);
        // R4: clear-all with simultaneous RX underflow event
        rx_empty = 1; rx_pop = 1; wdata = 16'h0001; wr_clr = 1; step();
        rx_empty = 0;
        #2; chk("R4 clear all", raw_irq[3:1], 3'b010); @(negedge clk);
        wdata = 16'h0004; wr_clr = 1; step();   // bit2 clears RX overflow (already 0)
        wdata = 16'h0002; wr_clr = 1; step();
        // R5: clear does not touch level bits
        tx_level = 0; rx_level = 3; wdata = 16'h000F; wr_clr = 1; step();
        #2; chk("R5 clear ignores levels", {raw_irq[4], raw_irq[0]}, 2'b11); @(negedge clk);

        // R10: TX threshold written; visible next cycle. Boundary equal.
        tx_level = 5; wdata = 16'd5; wr_tx_thr = 1;
        #2; chk("R10 before write", raw_irq[0], 1'b0); #0;
        @(negedge clk); idle();
        #2; chk("R10 after write", raw_irq[0], 1'b1); @(negedge clk);
        m_tx_thr = 5;
        tx_level = 6; step();
        // RX boundary: level equal to threshold is not above
        rx_level = 7; wdata = 16'd7; wr_rx_thr = 1; step();
        step();
        rx_level = 8; step();

        // R8: DMA watermarks and enables
        wdata = 16'd4; wr_tx_wm = 1; step();
        wdata = 16'd10; wr_rx_wm = 1; step();
        wdata = 16'h0003; wr_dma = 1; tx_level = 4; rx_level = 10; step();
        step();
        rx_level = 11; step();
        tx_level = 5; step();
        wdata = 16'h0001; wr_dma = 1; tx_level = 0; step();
        step();

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            busy     = 1'($urandom);
            tx_full  = 1'($urandom);
            tx_empty = 1'($urandom);
            rx_full  = 1'($urandom);
            rx_empty = 1'($urandom);
            tx_level = LVL_W'($urandom_range(0, DEPTH));
            rx_level = LVL_W'($urandom_range(0, DEPTH));
            tx_push  = ($urandom_range(0, 7) == 0);
            rx_pop   = ($urandom_range(0, 7) == 0);
            rx_wr    = ($urandom_range(0, 7) == 0);
            wdata    = WDATA_W'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 3) == 0) wdata = WDATA_W'($urandom);
            case ($urandom_range(0, 15))
                0: wr_tx_thr = 1;
                1: wr_rx_thr = 1;
                2: wr_mask = 1;
                3, 4: wr_clr = 1;
                5: wr_dma = 1;
                6: wr_tx_wm = 1;
                7: wr_rx_wm = 1;
                default: ;
            endcase
            step();
        end

        done = 1;
        finish_run();
    end
endmodule